// File: doc/BRIEF.md
# Chained Debug Trigger Match Unit

This block holds ten hardware breakpoint triggers. Each trigger compares one observed value (a fetch address, a load address, a store address or store data) against a programmed 64-bit reference and reports a match. The triggers form five fixed pairs. The lower member of a pair can join the two into a chain, so that the pair fires only when both members match on the same observation.

Software-side logic programs each trigger through a single valid-qualified write port. Fetch-side triggers and memory-side triggers each have their own index space. Every cycle the block samples the fetch, load and store observation channels. One cycle later it presents per-trigger hit bits, a combined hit flag, a timing flag (trap before or after the instruction) and an action flag for the trap logic downstream.

Top module: `trig_bank`

## Requirements
- R1: A write with `cfg_wr_valid_i` high stores the full configuration into one trigger, and the new configuration governs observations from the next cycle on. With `cfg_wr_mem_i`=0, index 0..3 selects triggers 0, 1, 6 and 8. With `cfg_wr_mem_i`=1, index 0..5 selects triggers 2, 3, 4, 5, 7 and 9. A memory-side index of 6 or 7 changes nothing.
- R2: Reset clears every configuration (including every enable) and every output.
- R3: Match type 0 hits when the observed value equals the reference. Type 1 hits inside an aligned power-of-two range: if the reference has k trailing ones, the low k+1 bits are ignored. Type 2 hits when observed >= reference and type 3 when observed < reference. All comparisons are unsigned over 64 bits.
- R4: On store triggers, select=1 compares store data and select=0 compares the store address. Fetch and load triggers with select=1 never hit.
- R5: A trigger looks only at its own channel, and only while that channel's valid is high. The trigger-to-channel mapping is: 0, 1, 6, 8 fetch; 4, 5, 9 load; 2, 3, 7 store. Hit outputs appear on the cycle after the observation.
- R6: A trigger whose enable bit is clear never hits.
- R7: The chain bit of trigger 2p joins pairs 2p and 2p+1. A chained pair sets both hit bits when both members match and are enabled, and sets neither otherwise. The chain bit of an odd trigger has no effect.
- R8: A chained pair whose two timing bits differ never hits.
- R9: Pair 2/3 (both store triggers) never hits while chained.
- R10: `any_hit_o` is the OR of all hit bits. `hit_timing_o` is 1 only when a hit is present and every hitting trigger has timing=1 (trap after). `hit_action_o` is the OR of the action bits of the hitting triggers.
- R11: Output bit k of `fetch_hit_o` reports fetch-side trigger index k, and bit k of `mem_hit_o` reports memory-side index k, with the same mapping as R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_valid_i | input | 1 | Configuration write strobe |
| cfg_wr_mem_i | input | 1 | 0 = fetch-side index space, 1 = memory-side |
| cfg_wr_idx_i | input | 3 | Trigger index within the chosen side |
| cfg_wr_en_i | input | 1 | Trigger enable |
| cfg_wr_mtype_i | input | 2 | Match type (R3) |
| cfg_wr_sel_i | input | 1 | Compare store data instead of address |
| cfg_wr_timing_i | input | 1 | 0 trap before, 1 trap after |
| cfg_wr_action_i | input | 1 | Action flag reported with hits |
| cfg_wr_chain_i | input | 1 | Chain with the odd partner (even triggers) |
| cfg_wr_value_i | input | XLEN | Reference value |
| fetch_valid_i | input | 1 | Fetch observation valid |
| fetch_pc_i | input | XLEN | Fetch address |
| load_valid_i | input | 1 | Load observation valid |
| load_addr_i | input | XLEN | Load address |
| store_valid_i | input | 1 | Store observation valid |
| store_addr_i | input | XLEN | Store address |
| store_data_i | input | XLEN | Store data |
| fetch_hit_o | output | 4 | Fetch-side hits, by fetch index |
| mem_hit_o | output | 6 | Memory-side hits, by memory index |
| any_hit_o | output | 1 | Any trigger hit |
| hit_timing_o | output | 1 | Trap-after indication |
| hit_action_o | output | 1 | OR of action bits of hitting triggers |

## Verification
The checker watches the following on every cycle, for whatever configuration happens to be loaded:
- the members of a chained pair always agree;
- mismatched timing, a store/store chain, a cleared enable, or select on a fetch or load trigger each silence their hits;
- idle channels give no hit.

Only the bench's scenarios can show that the hits that do appear are correct. That covers:
- the four comparison rules, including both edges of a range;
- the index-to-trigger mapping and the rejected memory indices 6 and 7;
- the one-cycle delay before a write takes effect;
- the timing and action summaries.

A behavioural reference model covers all of these, with directed and random traffic.

// File: rtl/trig_pkg.sv
package trig_pkg;

    localparam int NUM_TRIG  = 10;
    localparam int NUM_PAIR  = NUM_TRIG / 2;
    localparam int NUM_FETCH = 4;
    localparam int NUM_MEM   = NUM_TRIG - NUM_FETCH;
    localparam int FIDX_W    = $clog2(NUM_FETCH);
    localparam int MIDX_W    = $clog2(NUM_MEM);

    typedef enum logic [1:0] {
        MATCH_EQ    = 2'd0,
        MATCH_NAPOT = 2'd1,
        MATCH_GE    = 2'd2,
        MATCH_LT    = 2'd3
    } match_e;

    typedef enum logic [1:0] {
        SRC_FETCH = 2'd0,
        SRC_LOAD  = 2'd1,
        SRC_STORE = 2'd2
    } src_e;

    typedef struct packed {
        logic   en;
        match_e mtype;
        logic   sel;
        logic   timing;
        logic   action;
        logic   chain;
    } trig_ctrl_t;

    // Observation channel watched by each global trigger number
    function automatic src_e trig_src(input int t);
        case (t)
            0, 1, 6, 8: return SRC_FETCH;
            4, 5, 9:    return SRC_LOAD;
            default:    return SRC_STORE;
        endcase
    endfunction

    // Fetch-side index -> global trigger number
    function automatic int fetch_slot(input int k);
        case (k)
            0:       return 0;
            1:       return 1;
            2:       return 6;
            default: return 8;
        endcase
    endfunction

    // Memory-side index -> global trigger number
    function automatic int mem_slot(input int k);
        case (k)
            0:       return 2;
            1:       return 3;
            2:       return 4;
            3:       return 5;
            4:       return 7;
            default: return 9;
        endcase
    endfunction

endpackage

// File: rtl/trig_cmp.sv
module trig_cmp #(
    parameter int W = 64
) (
    input  trig_pkg::match_e mtype_i,
    input  logic [W-1:0]     ref_i,
    input  logic [W-1:0]     obs_i,
    output logic             match_o
);
    import trig_pkg::*;

    // Ones over the trailing-one run of the reference plus the first zero
    logic [W-1:0] span;
    assign span = ref_i ^ (ref_i + W'(1));

    always_comb begin
        case (mtype_i)
            MATCH_EQ:    match_o = (obs_i == ref_i);
            MATCH_NAPOT: match_o = (((obs_i ^ ref_i) & ~span) == '0);
            MATCH_GE:    match_o = (obs_i >= ref_i);
            default:     match_o = (obs_i < ref_i);
        endcase
    end
endmodule

// File: rtl/trig_pair.sv
module trig_pair #(
    parameter bit SAME_STORE = 1'b0
) (
    input  logic       match_lo_i,
    input  logic       match_hi_i,
    input  logic       en_lo_i,
    input  logic       en_hi_i,
    input  logic       timing_lo_i,
    input  logic       timing_hi_i,
    input  logic       chain_i,
    output logic [1:0] hit_o
);
    logic arm_lo;
    logic arm_hi;
    logic joint;

    assign arm_lo = match_lo_i & en_lo_i;
    assign arm_hi = match_hi_i & en_hi_i;

    generate
        if (SAME_STORE) begin : g_forbid
            assign joint = 1'b0;
        end else begin : g_allow
            assign joint = arm_lo & arm_hi & (timing_lo_i == timing_hi_i);
        end
    endgenerate

    always_comb begin
        if (chain_i) hit_o = {2{joint}};
        else         hit_o = {arm_hi, arm_lo};
    end
endmodule

// File: rtl/trig_bank.sv
module trig_bank #(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_wr_valid_i,
    input  logic            cfg_wr_mem_i,
    input  logic [2:0]      cfg_wr_idx_i,
    input  logic            cfg_wr_en_i,
    input  logic [1:0]      cfg_wr_mtype_i,
    input  logic            cfg_wr_sel_i,
    input  logic            cfg_wr_timing_i,
    input  logic            cfg_wr_action_i,
    input  logic            cfg_wr_chain_i,
    input  logic [XLEN-1:0] cfg_wr_value_i,
    input  logic            fetch_valid_i,
    input  logic [XLEN-1:0] fetch_pc_i,
    input  logic            load_valid_i,
    input  logic [XLEN-1:0] load_addr_i,
    input  logic            store_valid_i,
    input  logic [XLEN-1:0] store_addr_i,
    input  logic [XLEN-1:0] store_data_i,
    output logic [3:0]      fetch_hit_o,
    output logic [5:0]      mem_hit_o,
    output logic            any_hit_o,
    output logic            hit_timing_o,
    output logic            hit_action_o
);
    import trig_pkg::*;

    localparam int NT = NUM_TRIG;
    localparam int NP = NUM_PAIR;

    typedef struct packed {
        trig_ctrl_t [NT-1:0]           ctrl;
        logic       [NT-1:0][XLEN-1:0] value;
        logic       [NT-1:0]           hit;
        logic                          timing;
        logic                          action;
    } state_t;

    state_t state_d, state_q;

    logic [NT-1:0] qual_match;
    logic [NT-1:0] pair_hit;
    logic [NT-1:0] wr_sel;
    trig_ctrl_t    wr_ctrl;
    logic          all_late;
    logic          act_or;

    // Per-trigger observation select and comparison
    for (genvar g = 0; g < NT; g++) begin : g_trig
        localparam src_e SRC = trig_src(g);
        logic [XLEN-1:0] obs;
        logic            gate;
        logic            cmp_hit;

        if (SRC == SRC_FETCH) begin : g_fetch
            assign obs  = fetch_pc_i;
            assign gate = fetch_valid_i & ~state_q.ctrl[g].sel;
        end else if (SRC == SRC_LOAD) begin : g_load
            assign obs  = load_addr_i;
            assign gate = load_valid_i & ~state_q.ctrl[g].sel;
        end else begin : g_store
            assign obs  = state_q.ctrl[g].sel ? store_data_i : store_addr_i;
            assign gate = store_valid_i;
        end

        trig_cmp #(.W(XLEN)) u_cmp (
            .mtype_i (state_q.ctrl[g].mtype),
            .ref_i   (state_q.value[g]),
            .obs_i   (obs),
            .match_o (cmp_hit)
        );

        assign qual_match[g] = gate & cmp_hit;
    end

    // Pairwise chaining
    for (genvar p = 0; p < NP; p++) begin : g_pair
        localparam bit SS = (trig_src(2*p) == SRC_STORE) && (trig_src(2*p+1) == SRC_STORE);
        trig_pair #(.SAME_STORE(SS)) u_pair (
            .match_lo_i  (qual_match[2*p]),
            .match_hi_i  (qual_match[2*p+1]),
            .en_lo_i     (state_q.ctrl[2*p].en),
            .en_hi_i     (state_q.ctrl[2*p+1].en),
            .timing_lo_i (state_q.ctrl[2*p].timing),
            .timing_hi_i (state_q.ctrl[2*p+1].timing),
            .chain_i     (state_q.ctrl[2*p].chain),
            .hit_o       (pair_hit[2*p+1:2*p])
        );
    end

    // Write decode: side-local index to global trigger number
    always_comb begin
        wr_sel = '0;
        if (cfg_wr_valid_i) begin
            if (cfg_wr_mem_i) begin
                for (int k = 0; k < NUM_MEM; k++)
                    if (cfg_wr_idx_i == 3'(k)) wr_sel[mem_slot(k)] = 1'b1;
            end else begin
                for (int k = 0; k < NUM_FETCH; k++)
                    if (cfg_wr_idx_i[FIDX_W-1:0] == FIDX_W'(k)) wr_sel[fetch_slot(k)] = 1'b1;
            end
        end
    end

    always_comb begin
        wr_ctrl.en     = cfg_wr_en_i;
        wr_ctrl.mtype  = match_e'(cfg_wr_mtype_i);
        wr_ctrl.sel    = cfg_wr_sel_i;
        wr_ctrl.timing = cfg_wr_timing_i;
        wr_ctrl.action = cfg_wr_action_i;
        wr_ctrl.chain  = cfg_wr_chain_i;
    end

    // Next-state computation
    always_comb begin
        state_d  = state_q;
        all_late = 1'b1;
        act_or   = 1'b0;
        for (int t = 0; t < NT; t++) begin
            if (wr_sel[t]) begin
                state_d.ctrl[t]  = wr_ctrl;
                state_d.value[t] = cfg_wr_value_i;
            end
            if (pair_hit[t]) begin
                if (!state_q.ctrl[t].timing) all_late = 1'b0;
                act_or = act_or | state_q.ctrl[t].action;
            end
        end
        state_d.hit    = pair_hit;
        state_d.timing = (|pair_hit) & all_late;
        state_d.action = act_or;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    // Output mapping back to side-local order
    for (genvar k = 0; k < NUM_FETCH; k++) begin : g_fout
        assign fetch_hit_o[k] = state_q.hit[fetch_slot(k)];
    end
    for (genvar k = 0; k < NUM_MEM; k++) begin : g_mout
        assign mem_hit_o[k] = state_q.hit[mem_slot(k)];
    end

    assign any_hit_o    = |state_q.hit;
    assign hit_timing_o = state_q.timing;
    assign hit_action_o = state_q.action;

endmodule

// File: rtl/trig_bank_chk.sv
module trig_bank_chk (
    input logic                                   clk,
    input logic                                   rst_n,
    input trig_pkg::trig_ctrl_t [trig_pkg::NUM_TRIG-1:0] ctrl_q,
    input logic [trig_pkg::NUM_TRIG-1:0]          hit_q,
    input logic                                   fetch_valid_i,
    input logic                                   load_valid_i,
    input logic                                   store_valid_i,
    input logic                                   any_hit_o,
    input logic                                   hit_timing_o
);
    import trig_pkg::*;

    // R5
    idle_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_valid_i && !load_valid_i && !store_valid_i) |=> !any_hit_o);

    // R10
    timing_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_timing_o |-> any_hit_o);

    for (genvar t = 0; t < NUM_TRIG; t++) begin : g_t
        // R6
        disabled_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !ctrl_q[t].en |=> !hit_q[t]);
        if (trig_src(t) != SRC_STORE) begin : g_nsel
            // R4
            sel_unsupported_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ctrl_q[t].sel |=> !hit_q[t]);
        end
    end

    for (genvar p = 0; p < NUM_PAIR; p++) begin : g_p
        // R7
        chain_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ctrl_q[2*p].chain |=> (hit_q[2*p] == hit_q[2*p+1]));
        // R8
        timing_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl_q[2*p].chain && (ctrl_q[2*p].timing != ctrl_q[2*p+1].timing))
            |=> (!hit_q[2*p] && !hit_q[2*p+1]));
        if (trig_src(2*p) == SRC_STORE && trig_src(2*p+1) == SRC_STORE) begin : g_ss
            // R9
            store_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ctrl_q[2*p].chain |=> (!hit_q[2*p] && !hit_q[2*p+1]));
        end
    end
endmodule

bind trig_bank trig_bank_chk u_trig_bank_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctrl_q        (state_q.ctrl),
    .hit_q         (state_q.hit),
    .fetch_valid_i (fetch_valid_i),
    .load_valid_i  (load_valid_i),
    .store_valid_i (store_valid_i),
    .any_hit_o     (any_hit_o),
    .hit_timing_o  (hit_timing_o)
);

// File: tb/trig_bank_bench.sv
module trig_bank_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr_valid_i = 0, cfg_wr_mem_i = 0;
    logic [2:0] cfg_wr_idx_i = 0;
    logic cfg_wr_en_i = 0;
    logic [1:0] cfg_wr_mtype_i = 0;
    logic cfg_wr_sel_i = 0, cfg_wr_timing_i = 0, cfg_wr_action_i = 0, cfg_wr_chain_i = 0;
    logic [W-1:0] cfg_wr_value_i = 0;
    logic fetch_valid_i = 0, load_valid_i = 0, store_valid_i = 0;
    logic [W-1:0] fetch_pc_i = 0, load_addr_i = 0, store_addr_i = 0, store_data_i = 0;
    logic [3:0] fetch_hit_o;
    logic [5:0] mem_hit_o;
    logic any_hit_o, hit_timing_o, hit_action_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    trig_bank #(.XLEN(W)) u_trig_bank (.*);

    int checks = 0;
    int errors = 0;
    string cur_req = "R2";
    bit started = 0;

    // Reference model state
    int kind [10] = '{0, 0, 2, 2, 1, 1, 0, 2, 0, 1}; // 0 fetch, 1 load, 2 store
    int fmap [4]  = '{0, 1, 6, 8};
    int mmap [6]  = '{2, 3, 4, 5, 7, 9};
    bit m_en [10], m_sel [10], m_tim [10], m_act [10], m_chn [10];
    int m_mt [10];
    logic [W-1:0] m_val [10];
    logic [3:0] e_f = 0;
    logic [5:0] e_m = 0;
    logic e_any = 0, e_tim = 0, e_act = 0;

    function automatic bit ref_cmp(int mt, logic [W-1:0] v, logic [W-1:0] o);
        int k;
        case (mt)
            0: return o == v;
            1: begin
                k = 0;
                while (k < W && v[k]) k++;
                return (o >> (k + 1)) == (v >> (k + 1));
            end
            2: return o >= v;
            default: return o < v;
        endcase
    endfunction

    always @(posedge clk) begin : model
        bit mt [10];
        bit ht [10];
        bit ok;
        bit late;
        started = 1;
        if (!rst_n) begin
            for (int t = 0; t < 10; t++) begin
                m_en[t] = 0; m_sel[t] = 0; m_tim[t] = 0; m_act[t] = 0; m_chn[t] = 0;
                m_mt[t] = 0; m_val[t] = 0;
            end
            e_f = 0; e_m = 0; e_any = 0; e_tim = 0; e_act = 0;
        end else begin
            for (int t = 0; t < 10; t++) begin
                mt[t] = 0;
                if (kind[t] == 0 && fetch_valid_i && !m_sel[t]) mt[t] = ref_cmp(m_mt[t], m_val[t], fetch_pc_i);
                if (kind[t] == 1 && load_valid_i && !m_sel[t])  mt[t] = ref_cmp(m_mt[t], m_val[t], load_addr_i);
                if (kind[t] == 2 && store_valid_i)
                    mt[t] = ref_cmp(m_mt[t], m_val[t], m_sel[t] ? store_data_i : store_addr_i);
                mt[t] = mt[t] && m_en[t];
            end
            for (int p = 0; p < 5; p++) begin
                if (m_chn[2*p]) begin
                    ok = mt[2*p] && mt[2*p+1] && (m_tim[2*p] == m_tim[2*p+1]) && (p != 1);
                    ht[2*p] = ok; ht[2*p+1] = ok;
                end else begin
                    ht[2*p] = mt[2*p]; ht[2*p+1] = mt[2*p+1];
                end
            end
            e_any = 0; late = 1; e_act = 0;
            for (int t = 0; t < 10; t++) if (ht[t]) begin
                e_any = 1;
                if (!m_tim[t]) late = 0;
                if (m_act[t]) e_act = 1;
            end
            e_tim = e_any && late;
            for (int k = 0; k < 4; k++) e_f[k] = ht[fmap[k]];
            for (int k = 0; k < 6; k++) e_m[k] = ht[mmap[k]];
            if (cfg_wr_valid_i && !(cfg_wr_mem_i && cfg_wr_idx_i > 5)) begin : apply
                int id;
                id = cfg_wr_mem_i ? mmap[cfg_wr_idx_i] : fmap[cfg_wr_idx_i[1:0]];
                m_en[id] = cfg_wr_en_i; m_mt[id] = cfg_wr_mtype_i; m_sel[id] = cfg_wr_sel_i;
                m_tim[id] = cfg_wr_timing_i; m_act[id] = cfg_wr_action_i; m_chn[id] = cfg_wr_chain_i;
                m_val[id] = cfg_wr_value_i;
            end
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) if (started) begin
        checks++;
        if (fetch_hit_o !== e_f || mem_hit_o !== e_m || any_hit_o !== e_any ||
            hit_timing_o !== e_tim || hit_action_o !== e_act) begin
            errors++;
            $display("FAIL %s model: got f=%b m=%b a=%b t=%b x=%b expected f=%b m=%b a=%b t=%b x=%b",
                     cur_req, fetch_hit_o, mem_hit_o, any_hit_o, hit_timing_o, hit_action_o,
                     e_f, e_m, e_any, e_tim, e_act);
        end
    end

    task automatic chk(string req, logic [3:0] ef, logic [5:0] em);
        checks++;
        if (fetch_hit_o !== ef || mem_hit_o !== em || any_hit_o !== (|{ef, em})) begin
            errors++;
            $display("FAIL %s: got f=%b m=%b any=%b expected f=%b m=%b any=%b",
                     req, fetch_hit_o, mem_hit_o, any_hit_o, ef, em, |{ef, em});
        end
    endtask

    task automatic chk_ta(string req, logic et, logic ea);
        checks++;
        if (hit_timing_o !== et || hit_action_o !== ea) begin
            errors++;
            $display("FAIL %s: got timing=%b action=%b expected timing=%b action=%b",
                     req, hit_timing_o, hit_action_o, et, ea);
        end
    endtask

    task automatic wr(bit mem, int idx, bit en, int mt, bit sel, bit tim, bit act, bit ch,
                      logic [W-1:0] v);
        @(negedge clk);
        cfg_wr_valid_i = 1; cfg_wr_mem_i = mem; cfg_wr_idx_i = 3'(idx); cfg_wr_en_i = en;
        cfg_wr_mtype_i = 2'(mt); cfg_wr_sel_i = sel; cfg_wr_timing_i = tim;
        cfg_wr_action_i = act; cfg_wr_chain_i = ch; cfg_wr_value_i = v;
        @(negedge clk);
        cfg_wr_valid_i = 0;
    endtask

    task automatic ob(bit fv, logic [W-1:0] pc, bit lv, logic [W-1:0] la,
                      bit sv, logic [W-1:0] sa, logic [W-1:0] sd);
        @(negedge clk);
        fetch_valid_i = fv; fetch_pc_i = pc; load_valid_i = lv; load_addr_i = la;
        store_valid_i = sv; store_addr_i = sa; store_data_i = sd;
        @(negedge clk);
        fetch_valid_i = 0; load_valid_i = 0; store_valid_i = 0;
    endtask

    function automatic logic [W-1:0] pick();
        case ($urandom_range(0, 5))
            0: return 64'h100;
            1: return 64'h1FF;
            2: return 64'h8000;
            3: return 64'h0;
            4: return 64'hFFFF_FFFF_FFFF_FFFF;
            default: return {32'h0, $urandom()};
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R2 reset state
        cur_req = "R2";
        chk("R2", 0, 0);
        chk_ta("R2", 0, 0);
        ob(1, 0, 1, 0, 1, 0, 0);
        chk("R2 R6", 0, 0);

        // R1: write and observe in the same cycle, effect on the next
        cur_req = "R1";
        @(negedge clk);
        cfg_wr_valid_i = 1; cfg_wr_mem_i = 0; cfg_wr_idx_i = 0; cfg_wr_en_i = 1;
        cfg_wr_mtype_i = 0; cfg_wr_sel_i = 0; cfg_wr_timing_i = 0; cfg_wr_action_i = 0;
        cfg_wr_chain_i = 0; cfg_wr_value_i = 64'h1000;
        fetch_valid_i = 1; fetch_pc_i = 64'h1000;
        @(negedge clk);
        cfg_wr_valid_i = 0;
        chk("R1 old config", 0, 0);
        @(negedge clk);
        fetch_valid_i = 0;
        chk("R1 new config", 4'b0001, 0);
        wr(1, 6, 1, 0, 0, 0, 0, 0, 64'h55);
        wr(1, 7, 1, 0, 0, 0, 0, 0, 64'h55);
        ob(0, 0, 1, 64'h55, 1, 64'h55, 64'h55);
        chk("R1 idx 6/7 ignored", 0, 0);

        // R3 match types
        cur_req = "R3";
        wr(0, 1, 1, 1, 0, 0, 0, 0, 64'h20FF);
        ob(1, 64'h21FF, 0, 0, 0, 0, 0); chk("R3 napot top", 4'b0010, 0);
        ob(1, 64'h2200, 0, 0, 0, 0, 0); chk("R3 napot above", 0, 0);
        ob(1, 64'h2000, 0, 0, 0, 0, 0); chk("R3 napot base", 4'b0010, 0);
        ob(1, 64'h1FFF, 0, 0, 0, 0, 0); chk("R3 napot below", 0, 0);
        wr(1, 0, 1, 2, 0, 0, 0, 0, 64'h8000);
        wr(1, 1, 1, 3, 0, 0, 0, 0, 64'h10);
        ob(0, 0, 0, 0, 1, 64'h8000, 0); chk("R3 ge equal", 0, 6'b000001);
        ob(0, 0, 0, 0, 1, 64'h7FFF, 0); chk("R3 ge below", 0, 0);
        ob(0, 0, 0, 0, 1, 64'h8, 0);    chk("R3 lt", 0, 6'b000010);
        ob(0, 0, 0, 0, 1, 64'h10, 0);   chk("R3 lt edge", 0, 0);
        ob(0, 0, 0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0); chk("R3 ge unsigned", 0, 6'b000001);

        // R4 select
        cur_req = "R4";
        wr(1, 0, 1, 0, 1, 0, 0, 0, 64'hDEAD);
        ob(0, 0, 0, 0, 1, 64'hDEAD, 0);     chk("R4 store addr ignored", 0, 0);
        ob(0, 0, 0, 0, 1, 64'h20, 64'hDEAD); chk("R4 store data", 0, 6'b000001);
        wr(1, 2, 1, 0, 1, 0, 0, 0, 64'h40);
        ob(0, 0, 1, 64'h40, 0, 0, 0);       chk("R4 load sel", 0, 0);
        wr(1, 2, 1, 0, 0, 0, 0, 0, 64'h40);
        ob(0, 0, 1, 64'h40, 0, 0, 0);       chk("R4 R5 load addr", 0, 6'b000100);
        wr(0, 1, 1, 1, 1, 0, 0, 0, 64'h20FF);
        ob(1, 64'h2000, 0, 0, 0, 0, 0);     chk("R4 fetch sel", 0, 0);
        wr(1, 0, 0, 0, 0, 0, 0, 0, 0);
        wr(1, 1, 0, 0, 0, 0, 0, 0, 0);
        wr(1, 2, 0, 0, 0, 0, 0, 0, 0);

        // R6 enable
        cur_req = "R6";
        wr(0, 0, 0, 0, 0, 0, 0, 0, 64'h1000);
        ob(1, 64'h1000, 0, 0, 0, 0, 0); chk("R6 disabled", 0, 0);

        // R7 chain
        cur_req = "R7";
        wr(0, 0, 1, 0, 0, 0, 0, 1, 64'h100);
        wr(0, 1, 1, 2, 0, 0, 0, 0, 64'h100);
        ob(1, 64'h100, 0, 0, 0, 0, 0); chk("R7 both", 4'b0011, 0);
        ob(1, 64'h200, 0, 0, 0, 0, 0); chk("R7 one member", 0, 0);
        wr(0, 1, 1, 2, 0, 0, 0, 1, 64'h300); // odd chain bit has no effect
        ob(1, 64'h200, 0, 0, 0, 0, 0); chk("R7 odd chain", 0, 0);
        ob(1, 64'h300, 0, 0, 0, 0, 0); chk("R7 odd chain lone", 0, 0);
        wr(0, 0, 1, 0, 0, 0, 0, 0, 64'h100);
        ob(1, 64'h300, 0, 0, 0, 0, 0); chk("R7 unchained", 4'b0010, 0);

        // R8 timing mismatch
        cur_req = "R8";
        wr(0, 0, 1, 0, 0, 0, 0, 1, 64'h100);
        wr(0, 1, 1, 2, 0, 1, 0, 0, 64'h100);
        ob(1, 64'h100, 0, 0, 0, 0, 0); chk("R8 mismatch", 0, 0);
        wr(0, 0, 1, 0, 0, 1, 1, 1, 64'h100);
        ob(1, 64'h100, 0, 0, 0, 0, 0); chk("R8 agree", 4'b0011, 0);
        chk_ta("R10 late pair", 1, 1);
        wr(0, 0, 0, 0, 0, 0, 0, 0, 0);
        wr(0, 1, 0, 0, 0, 0, 0, 0, 0);

        // R9 store/store chain
        cur_req = "R9";
        wr(1, 0, 1, 0, 0, 0, 0, 1, 64'h300);
        wr(1, 1, 1, 0, 0, 0, 0, 0, 64'h300);
        ob(0, 0, 0, 0, 1, 64'h300, 0); chk("R9 chained", 0, 0);
        wr(1, 0, 1, 0, 0, 0, 0, 0, 64'h300);
        ob(0, 0, 0, 0, 1, 64'h300, 0); chk("R9 unchained", 0, 6'b000011);
        wr(1, 0, 0, 0, 0, 0, 0, 0, 0);
        wr(1, 1, 0, 0, 0, 0, 0, 0, 0);

        // R11 mixed pairs
        cur_req = "R11";
        wr(0, 2, 1, 0, 0, 0, 0, 1, 64'h400);
        wr(1, 4, 1, 0, 0, 0, 0, 0, 64'h500);
        ob(1, 64'h400, 0, 0, 1, 64'h500, 0); chk("R11 fetch/store", 4'b0100, 6'b010000);
        ob(1, 64'h400, 0, 0, 0, 0, 0);       chk("R11 fetch only", 0, 0);
        wr(0, 3, 1, 0, 0, 0, 0, 1, 64'h600);
        wr(1, 5, 1, 0, 0, 0, 0, 0, 64'h700);
        ob(1, 64'h600, 1, 64'h700, 0, 0, 0); chk("R11 fetch/load", 4'b1000, 6'b100000);

        // R10 timing and action summary
        cur_req = "R10";
        wr(0, 2, 1, 0, 0, 0, 1, 0, 64'h400);
        wr(0, 3, 1, 0, 0, 1, 0, 0, 64'h400);
        ob(1, 64'h400, 0, 0, 0, 0, 0); chk("R10 two", 4'b1100, 0);
        chk_ta("R10 mixed timing", 0, 1);
        wr(0, 2, 0, 0, 0, 0, 1, 0, 64'h400);
        ob(1, 64'h400, 0, 0, 0, 0, 0); chk("R10 one", 4'b1000, 0);
        chk_ta("R10 late only", 1, 0);

        // R5 valids qualify
        cur_req = "R5";
        ob(0, 64'h400, 0, 64'h700, 0, 64'h500, 0); chk("R5 no valid", 0, 0);

        // Random traffic against the model
        cur_req = "R3 R7 R10 random";
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            cfg_wr_valid_i = ($urandom_range(0, 3) == 0);
            cfg_wr_mem_i = 1'($urandom()); cfg_wr_idx_i = 3'($urandom());
            cfg_wr_en_i = ($urandom_range(0, 3) != 0); cfg_wr_mtype_i = 2'($urandom());
            cfg_wr_sel_i = ($urandom_range(0, 3) == 0); cfg_wr_timing_i = 1'($urandom());
            cfg_wr_action_i = 1'($urandom()); cfg_wr_chain_i = 1'($urandom());
            cfg_wr_value_i = pick();
            fetch_valid_i = 1'($urandom()); fetch_pc_i = pick();
            load_valid_i = 1'($urandom()); load_addr_i = pick();
            store_valid_i = 1'($urandom()); store_addr_i = pick(); store_data_i = pick();
        end
        @(negedge clk);
        cfg_wr_valid_i = 0; fetch_valid_i = 0; load_valid_i = 0; store_valid_i = 0;
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got no completion expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule